// File: doc/BRIEF.md
# Low-Power Lane Mode-Entry Sequencer

This block controls the transmit side of one serial display data lane. While the lane is idle it holds both single-ended low-power lines high, which is the stop state. When asked for a high-speed burst, an escape session or a bus turnaround, it steps the two line bits through the request pattern for that mode. Each line state is held for a programmable number of clock cycles. At the end of the pattern it hands the lane to the high-speed transmitter, keeps it in escape, or stops driving so that the far end can take the bus.

An exit strobe ends a burst or an escape session, and the block walks the lines back to the stop state. After a turnaround the same strobe reclaims the lane. A one-cycle done pulse marks the end of every entry and exit pattern, and busy shows that a pattern or session is in progress. A parameter marks whether the instance serves lane 0. Only lane 0 accepts escape and turnaround requests.

Top module: `lp_lane_sequencer`

## Requirements
- R1: After reset and while idle, the lines read {lp_p,lp_n}=2'b11 with lp_oe=1, hs_oe=0, busy=0 and done=0.
- R2: A req_hs accepted in the stop state drives 2'b01 and then 2'b00. After that, hs_oe=1 and lp_oe=0 until an exit strobe.
- R3: req_exit during a high-speed burst sets hs_oe=0 and lp_oe=1 and drives 2'b11 for one dwell period. The lane then returns to the stop state.
- R4: An accepted req_esc drives 2'b10, 2'b00, 2'b01, 2'b00. The lane then stays in escape with 2'b00 driven, lp_oe=1 and busy=1.
- R5: req_exit during escape drives 2'b10 for one dwell period and then 2'b11 for one dwell period, and the lane then returns to the stop state.
- R6: An accepted req_bta drives 2'b10, 2'b00, 2'b10, 2'b00, then releases the lane (lp_oe=0, hs_oe=0, busy=0). A later req_exit puts the lane back into the stop state at once, with no done pulse.
- R7: With LANE_IS_ZERO=0, req_esc and req_bta are ignored and the lane stays in the stop state.
- R8: Every line state of a pattern is held for max(dwell_cfg,1) cycles. The value used is the dwell_cfg sampled when the entry request is accepted, and it also applies to the matching exit.
- R9: When several requests are present in the stop state, req_hs wins over req_esc, and req_esc wins over req_bta.
- R10: Requests that arrive while a pattern or session is in progress have no effect, and busy stays 1 until the lane reaches the stop state or is released.
- R11: done is a single-cycle pulse. It appears in the first cycle after each entry or exit pattern completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dwell_cfg | input | DWELL_W | Cycles per line state; 0 acts as 1 |
| req_hs | input | 1 | Request high-speed burst entry |
| req_esc | input | 1 | Request escape entry (lane 0 only) |
| req_bta | input | 1 | Request bus turnaround (lane 0 only) |
| req_exit | input | 1 | End burst, leave escape, or reclaim a released lane |
| lp_p | output | 1 | Low-power level on the positive line |
| lp_n | output | 1 | Low-power level on the negative line |
| lp_oe | output | 1 | Low-power driver enable |
| hs_oe | output | 1 | High-speed transmitter enable |
| busy | output | 1 | Pattern or session in progress |
| done | output | 1 | One-cycle pulse at the end of a pattern |

## Verification
If the mode or the step index is wrong, the line pair shows a different level in the very cycle the wrong state is taken, because the line bits decode directly from the registered state. An off-by-one in the dwell counter moves every step boundary by one cycle, and the bench compares the lines on every cycle of every step. A wrong transition out of the last step shows up within one cycle as a missing or misplaced done pulse, or as the wrong enable pattern. Stray requests and dwell changes are injected during patterns so that state corrupted by them would appear as a level mismatch.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;

    typedef enum logic [3:0] {
        M_STOP,
        M_HS_ENT,
        M_HS_ACT,
        M_HS_EXT,
        M_ESC_ENT,
        M_ESC_ACT,
        M_ESC_EXT,
        M_BTA_ENT,
        M_RELEASED
    } lane_mode_e;

    localparam logic [1:0] LV_00 = 2'b00;
    localparam logic [1:0] LV_01 = 2'b01;
    localparam logic [1:0] LV_10 = 2'b10;
    localparam logic [1:0] LV_11 = 2'b11;

endpackage

// File: rtl/lp_step_table.sv
module lp_step_table
    import lpseq_pkg::*;
(
    input  lane_mode_e mode,
    input  logic [1:0] step,
    output logic [1:0] level,
    output logic       last
);

    always_comb begin
        level = LV_11;
        last  = 1'b1;
        case (mode)
            M_HS_ENT: begin
                level = (step == 2'd0) ? LV_01 : LV_00;
                last  = (step == 2'd1);
            end
            M_HS_EXT: begin
                level = LV_11;
                last  = 1'b1;
            end
            M_ESC_ENT: begin
                case (step)
                    2'd0:    level = LV_10;
                    2'd1:    level = LV_00;
                    2'd2:    level = LV_01;
                    default: level = LV_00;
                endcase
                last = (step == 2'd3);
            end
            M_ESC_EXT: begin
                level = (step == 2'd0) ? LV_10 : LV_11;
                last  = (step == 2'd1);
            end
            M_BTA_ENT: begin
                level = step[0] ? LV_00 : LV_10;
                last  = (step == 2'd3);
            end
            default: begin
                level = LV_11;
                last  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/lp_dwell_timer.sv
module lp_dwell_timer #(
    parameter int DWELL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [DWELL_W-1:0] dwell,
    output logic               expire
);

    logic [DWELL_W-1:0] cnt_d, cnt_q;

    assign expire = (cnt_q == dwell - 1'b1);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (restart) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lp_lane_sequencer.sv
module lp_lane_sequencer
    import lpseq_pkg::*;
#(
    parameter int   DWELL_W      = 8,
    parameter logic LANE_IS_ZERO = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DWELL_W-1:0] dwell_cfg,
    input  logic               req_hs,
    input  logic               req_esc,
    input  logic               req_bta,
    input  logic               req_exit,
    output logic               lp_p,
    output logic               lp_n,
    output logic               lp_oe,
    output logic               hs_oe,
    output logic               busy,
    output logic               done
);

    localparam logic [DWELL_W-1:0] DWELL_MIN = DWELL_W'(1);

    typedef struct packed {
        lane_mode_e         mode;
        logic [1:0]         step;
        logic [DWELL_W-1:0] dwell;
        logic               done;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic       in_seq;
    logic       tmr_last;
    logic       tbl_last;
    logic [1:0] tbl_level;
    logic [1:0] lines;

    lp_step_table u_table (
        .mode  (s_q.mode),
        .step  (s_q.step),
        .level (tbl_level),
        .last  (tbl_last)
    );

    lp_dwell_timer #(.DWELL_W(DWELL_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (!in_seq || tmr_last),
        .dwell   (s_q.dwell),
        .expire  (tmr_last)
    );

    always_comb begin
        case (s_q.mode)
            M_HS_ENT, M_HS_EXT, M_ESC_ENT, M_ESC_EXT, M_BTA_ENT: in_seq = 1'b1;
            default:                                             in_seq = 1'b0;
        endcase
    end

    // Output decode from registered state
    always_comb begin
        lines = LV_11;
        lp_oe = 1'b1;
        hs_oe = 1'b0;
        busy  = 1'b1;
        case (s_q.mode)
            M_STOP:     busy = 1'b0;
            M_HS_ACT: begin
                lines = LV_00;
                lp_oe = 1'b0;
                hs_oe = 1'b1;
            end
            M_ESC_ACT:  lines = LV_00;
            M_RELEASED: begin
                lines = LV_00;
                lp_oe = 1'b0;
                busy  = 1'b0;
            end
            default:    lines = tbl_level;
        endcase
    end

    assign lp_p = lines[1];
    assign lp_n = lines[0];
    assign done = s_q.done;

    // Next-state computation
    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.mode)
            M_STOP: begin
                s_d.step  = 2'd0;
                s_d.dwell = (dwell_cfg == '0) ? DWELL_MIN : dwell_cfg;
                if (req_hs) begin
                    s_d.mode = M_HS_ENT;
                end else if (req_esc && LANE_IS_ZERO) begin
                    s_d.mode = M_ESC_ENT;
                end else if (req_bta && LANE_IS_ZERO) begin
                    s_d.mode = M_BTA_ENT;
                end
            end
            M_HS_ACT: begin
                if (req_exit) begin
                    s_d.mode = M_HS_EXT;
                    s_d.step = 2'd0;
                end
            end
            M_ESC_ACT: begin
                if (req_exit) begin
                    s_d.mode = M_ESC_EXT;
                    s_d.step = 2'd0;
                end
            end
            M_RELEASED: begin
                if (req_exit) begin
                    s_d.mode = M_STOP;
                end
            end
            default: begin
                if (tmr_last) begin
                    if (tbl_last) begin
                        s_d.step = 2'd0;
                        s_d.done = 1'b1;
                        case (s_q.mode)
                            M_HS_ENT:  s_d.mode = M_HS_ACT;
                            M_ESC_ENT: s_d.mode = M_ESC_ACT;
                            M_BTA_ENT: s_d.mode = M_RELEASED;
                            default:   s_d.mode = M_STOP;
                        endcase
                    end else begin
                        s_d.step = s_q.step + 2'd1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode  <= M_STOP;
            s_q.step  <= 2'd0;
            s_q.dwell <= DWELL_MIN;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: high-speed driver never overlaps the low-power driver
    p_no_drive_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_oe && lp_oe));

    // R2: high-speed enable only follows an LP00 level
    p_hs_after_lp00_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_oe) |-> ($past(lp_oe) && $past({lp_p, lp_n}) == LV_00));

    // R6: dropping the low-power driver follows LP00
    p_release_after_lp00_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lp_oe) |-> ($past({lp_p, lp_n}) == LV_00));

    // R3: regaining the low-power driver starts at LP11
    p_regain_at_lp11_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_oe) |-> ({lp_p, lp_n} == LV_11));

    // R11: done lasts a single cycle
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a driven lane that is not busy shows the stop level
    p_idle_is_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && lp_oe) |-> ({lp_p, lp_n} == LV_11));

    generate
        if (!LANE_IS_ZERO) begin : g_other_lane
            // R7: lanes other than 0 never form the LP10 level
            p_no_lp10_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !(lp_oe && {lp_p, lp_n} == LV_10));
        end
    endgenerate

endmodule

// File: tb/tb_lp_lane_sequencer.sv
module tb_lp_lane_sequencer;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] dwell_cfg = 8'd1;
    logic          req_hs = 0, req_esc = 0, req_bta = 0, req_exit = 0;
    logic          lp_p, lp_n, lp_oe, hs_oe, busy, done;

    logic [DW-1:0] l1_dwell = 8'd2;
    logic          l1_hs = 0, l1_esc = 0, l1_bta = 0, l1_exit = 0;
    logic          l1_p, l1_n, l1_oe, l1_hsoe, l1_busy, l1_done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lp_lane_sequencer #(.DWELL_W(DW), .LANE_IS_ZERO(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .dwell_cfg(dwell_cfg),
        .req_hs(req_hs), .req_esc(req_esc), .req_bta(req_bta), .req_exit(req_exit),
        .lp_p(lp_p), .lp_n(lp_n), .lp_oe(lp_oe), .hs_oe(hs_oe),
        .busy(busy), .done(done)
    );

    lp_lane_sequencer #(.DWELL_W(DW), .LANE_IS_ZERO(1'b0)) dut_l1 (
        .clk(clk), .rst_n(rst_n), .dwell_cfg(l1_dwell),
        .req_hs(l1_hs), .req_esc(l1_esc), .req_bta(l1_bta), .req_exit(l1_exit),
        .lp_p(l1_p), .lp_n(l1_n), .lp_oe(l1_oe), .hs_oe(l1_hsoe),
        .busy(l1_busy), .done(l1_done)
    );

    // kinds: 0 hs entry, 1 hs exit, 2 esc entry, 3 esc exit, 4 bta entry
    function automatic int seq_len(input int kind);
        case (kind)
            0: return 2;
            1: return 1;
            2: return 4;
            3: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [1:0] seq_lvl(input int kind, input int idx);
        case (kind)
            0: return (idx == 0) ? 2'b01 : 2'b00;
            1: return 2'b11;
            2: case (idx)
                   0: return 2'b10;
                   1: return 2'b00;
                   2: return 2'b01;
                   default: return 2'b00;
               endcase
            3: return (idx == 0) ? 2'b10 : 2'b11;
            default: return idx[0] ? 2'b00 : 2'b10;
        endcase
    endfunction

    // {lines, lp_oe, hs_oe, busy, done}; lines ignored when lp_oe expected 0
    function automatic logic [5:0] expect_after(input int kind);
        case (kind)
            0: return 6'b00_0_1_1_1;
            2: return 6'b00_1_0_1_1;
            4: return 6'b00_0_0_0_1;
            default: return 6'b11_1_0_0_1;
        endcase
    endfunction

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        logic [5:0] a, e;
        a = act;
        e = exp;
        if (!exp[3]) begin
            a[5:4] = 2'b00;
            e[5:4] = 2'b00;
        end
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, a, e, $time);
        end
    endtask

    function automatic logic [5:0] obs0();
        return {lp_p, lp_n, lp_oe, hs_oe, busy, done};
    endfunction

    function automatic logic [5:0] obs1();
        return {l1_p, l1_n, l1_oe, l1_hsoe, l1_busy, l1_done};
    endfunction

    // Walk a pattern of the given kind on lane 0; eff = held cycles per step.
    task automatic walk(input int kind, input int eff, input bit noise, input string req);
        for (int s = 0; s < seq_len(kind); s++) begin
            for (int c = 0; c < eff; c++) begin
                chk(req, obs0(), {seq_lvl(kind, s), 4'b1_0_1_0});
                if (noise) begin
                    req_hs    = 1'($urandom_range(0, 1));
                    req_esc   = 1'($urandom_range(0, 1));
                    req_bta   = 1'($urandom_range(0, 1));
                    dwell_cfg = 8'($urandom_range(0, 9));
                end
                @(negedge clk);
            end
        end
        req_hs = 0; req_esc = 0; req_bta = 0;
        chk({req, "/R11"}, obs0(), expect_after(kind));
        @(negedge clk);
        chk("R11", {5'b0, done}, 6'b0);
    endtask

    task automatic pulse_exit();
        req_exit = 1;
        @(negedge clk);
        req_exit = 0;
    endtask

    task automatic accept(input logic h, input logic e, input logic b, input logic [DW-1:0] d);
        dwell_cfg = d;
        req_hs = h; req_esc = e; req_bta = b;
        @(negedge clk);
        req_hs = 0; req_esc = 0; req_bta = 0;
    endtask

    task automatic hold_idle(input int kind, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            req_hs  = 1'($urandom_range(0, 1));
            req_esc = 1'($urandom_range(0, 1));
            req_bta = 1'($urandom_range(0, 1));
            chk(req, obs0(), {expect_after(kind)[5:1], 1'b0});
            @(negedge clk);
        end
        req_hs = 0; req_esc = 0; req_bta = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int eff;
        int op;
        int d;
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", obs0(), 6'b11_1_0_0_0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", obs0(), 6'b11_1_0_0_0);
        chk("R1", obs1(), 6'b11_1_0_0_0);

        // R8: dwell 0 acts as 1; R2 / R3 high-speed entry and exit
        accept(1, 0, 0, 8'd0);
        walk(0, 1, 0, "R2/R8");
        pulse_exit();
        walk(1, 1, 0, "R3/R8");

        // R9: all three together pick high-speed
        accept(1, 1, 1, 8'd3);
        walk(0, 3, 0, "R9");
        pulse_exit();
        walk(1, 3, 0, "R3");

        // R9: escape beats turnaround; R4 / R5
        accept(0, 1, 1, 8'd2);
        walk(2, 2, 0, "R9/R4");
        hold_idle(2, 4, "R10");
        pulse_exit();
        walk(3, 2, 0, "R5");

        // R6: turnaround, release, reclaim
        accept(0, 0, 1, 8'd1);
        walk(4, 1, 0, "R6");
        hold_idle(4, 3, "R6/R10");
        pulse_exit();
        chk("R6", obs0(), 6'b11_1_0_0_0);

        // R7: non-zero lane ignores escape and turnaround
        l1_esc = 1;
        @(negedge clk);
        l1_esc = 0;
        chk("R7", obs1(), 6'b11_1_0_0_0);
        l1_bta = 1;
        @(negedge clk);
        l1_bta = 0;
        for (int i = 0; i < 4; i++) begin
            chk("R7", obs1(), 6'b11_1_0_0_0);
            @(negedge clk);
        end
        l1_hs = 1;
        @(negedge clk);
        l1_hs = 0;
        chk("R7", obs1(), 6'b01_1_0_1_0);
        repeat (2) @(negedge clk);
        chk("R7", obs1(), 6'b00_1_0_1_0);
        repeat (2) @(negedge clk);
        chk("R7", obs1(), 6'b00_0_1_1_1);

        // Random mix; R10 noise and R8 dwell changes mid-pattern
        for (int it = 0; it < 80; it++) begin
            d   = $urandom_range(0, 6);
            eff = (d == 0) ? 1 : d;
            op  = $urandom_range(0, 2);
            if (op == 0) begin
                accept(1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'(d));
                walk(0, eff, 1, "R2/R10");
                hold_idle(0, $urandom_range(0, 3), "R10");
                pulse_exit();
                walk(1, eff, 1, "R3/R8");
            end else if (op == 1) begin
                accept(0, 1, 1'($urandom_range(0, 1)), 8'(d));
                walk(2, eff, 1, "R4/R10");
                hold_idle(2, $urandom_range(0, 3), "R10");
                pulse_exit();
                walk(3, eff, 1, "R5/R8");
            end else begin
                accept(0, 0, 1, 8'(d));
                walk(4, eff, 1, "R6/R10");
                hold_idle(4, $urandom_range(0, 3), "R6");
                pulse_exit();
                chk("R6", obs0(), 6'b11_1_0_0_0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule